// File: doc/BRIEF.md
# Equivalent State Finder

This block takes the transition table of a small sequential machine with one binary input and works out which of its states are interchangeable. A write port loads, for each state, the next state and the output for input 0 and for input 1. A start pulse then launches an iterative pair-marking search. First, every pair whose outputs disagree is marked as distinguishable. Then the engine sweeps the pair table again and again. A pair becomes distinguishable once one of the next-state pairs it leads to is already distinguishable. The sweeps stop after a complete sweep adds no new mark.

When the search settles, the block raises `done`. It presents three results: a full pairwise equivalence matrix, a map that names for each state the lowest-numbered state it is equivalent to, and the number of distinct equivalence classes. A state-assignment or synthesis step can use these results to shrink the machine before flip-flops are allocated. Each sweep visits one pair per clock, so a run takes a whole number of 28-cycle sweeps for the default size of eight states.

Top module: `state_equiv_finder`

## Requirements
- R1: After reset, `busy`, `done` and `overflow` are low and `num_classes` reads 0.
- R2: Two in-range states whose output for input 0 differs, or whose output for input 1 differs, are reported as not equivalent.
- R3: A pair whose next-state pair, for either input, is not equivalent is itself reported as not equivalent. This holds however many sweeps the propagation takes.
- R4: A next-state pair is disregarded when both of its states are the same, or when it names the same two states as the pair under test. A pair with matching outputs and only disregarded next-state pairs is reported as equivalent.
- R5: Only states below `num_states` take part. A value above the table size is treated as the table size. A state at or above that limit is equivalent to no other state, has its diagonal bit of `eq_pairs` low, maps to itself in `rep_map`, and is not counted. An in-range pair that leads to two distinct next states, one of them out of range, is not equivalent.
- R6: Once `done` is high, `rep_map` holds for each in-range state the lowest-numbered state equivalent to it (itself if none). `num_classes` equals the number of in-range states that map to themselves. Bit i*8+j of `eq_pairs` is 1 exactly when states i and j are equivalent, and the diagonal is 1 for in-range states.
- R7: `busy` rises in the cycle after a start pulse taken while idle. `done` rises as `busy` falls and stays high until the next accepted start. A start pulse during a run is ignored and does not change the run's length.
- R8: Table writes presented while `busy` is high leave the table unchanged.
- R9: `overflow` can be high only together with `done`. It is set only when the sweep limit of `num_states`−1 refinement sweeps is reached with marks still being added, and stays low for any table that converges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table entry write strobe |
| wr_state | input | 3 | State whose entry is written |
| wr_ns0 | input | 3 | Next state for input 0 |
| wr_ns1 | input | 3 | Next state for input 1 |
| wr_out0 | input | 1 | Output for input 0 |
| wr_out1 | input | 1 | Output for input 1 |
| num_states | input | 4 | Number of states in use, captured at start |
| start | input | 1 | Launch a search |
| busy | output | 1 | Search in progress |
| done | output | 1 | Results valid |
| overflow | output | 1 | Sweep limit reached before convergence |
| eq_pairs | output | 64 | Equivalence matrix, bit i*8+j for states i and j |
| rep_map | output | 24 | Representative state for state i at bits 3i+2..3i |
| num_classes | output | 4 | Number of equivalence classes |

## Verification
The embedded properties assume that `start` and the write strobe are known after reset. They also assume that results are read only while `done` is high, because the matrix and the map change freely during a sweep. The stimulus loads tables only while the engine is idle, with one exception: one case deliberately writes during a run to show that the write is dropped. It pulses `start` for a single cycle and holds the table steady between loading and the end of each run. In one case a second start is placed inside a run to probe the ignore rule.

// File: rtl/state_equiv_finder.sv
module state_equiv_finder #(
  parameter int NS = 8,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(NS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SW-1:0]      wr_state,
  input  logic [SW-1:0]      wr_ns0,
  input  logic [SW-1:0]      wr_ns1,
  input  logic               wr_out0,
  input  logic               wr_out1,
  input  logic [CW-1:0]      num_states,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               overflow,
  output logic [NS*NS-1:0]   eq_pairs,
  output logic [NS*SW-1:0]   rep_map,
  output logic [CW-1:0]      num_classes
);
  localparam int NP = NS * (NS - 1) / 2;
  localparam int PW = $clog2(NP);

  typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_REF} phase_t;

  phase_t ph;
  logic [NS-1:0][SW-1:0] tns0, tns1;
  logic [NS-1:0]         tout0, tout1;
  logic [NP-1:0]         mark;
  logic [SW-1:0]         pi, pj;
  logic [CW-1:0]         nlim, pass_cnt;
  logic                  changed;

  function automatic logic [PW-1:0] pidx(input logic [SW-1:0] a, input logic [SW-1:0] b);
    int lo, hi;
    lo = (a < b) ? int'(a) : int'(b);
    hi = (a < b) ? int'(b) : int'(a);
    return PW'(lo * (2 * NS - lo - 1) / 2 + hi - lo - 1);
  endfunction

  function automatic logic inr(input logic [SW-1:0] s);
    return CW'(s) < nlim;
  endfunction

  // table load, locked while a search runs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tns0 <= '0; tns1 <= '0; tout0 <= '0; tout1 <= '0;
    end else if (wr_en && !busy) begin
      tns0[wr_state]  <= wr_ns0;
      tns1[wr_state]  <= wr_ns1;
      tout0[wr_state] <= wr_out0;
      tout1[wr_state] <= wr_out1;
    end
  end

  logic [SW-1:0] a0, b0, a1, b1;
  logic ig0, ig1, oor0, oor1, outdiff, init_mark, imp_mark, last_pair, set_now, quiet;
  logic [CW-1:0] cap, nclamp;

  assign a0 = tns0[pi];
  assign b0 = tns0[pj];
  assign a1 = tns1[pi];
  assign b1 = tns1[pj];
  assign ig0 = (a0 == b0) || (a0 == pi && b0 == pj) || (a0 == pj && b0 == pi);
  assign ig1 = (a1 == b1) || (a1 == pi && b1 == pj) || (a1 == pj && b1 == pi);
  assign oor0 = !ig0 && (!inr(a0) || !inr(b0));
  assign oor1 = !ig1 && (!inr(a1) || !inr(b1));
  assign outdiff = (tout0[pi] != tout0[pj]) || (tout1[pi] != tout1[pj]);
  assign init_mark = !inr(pj) || outdiff || oor0 || oor1;
  assign imp_mark = (!ig0 && mark[pidx(a0, b0)]) || (!ig1 && mark[pidx(a1, b1)]);
  assign last_pair = (pi == SW'(NS - 2)) && (pj == SW'(NS - 1));
  assign set_now = !mark[pidx(pi, pj)] && imp_mark;
  assign quiet = !(changed || set_now);
  assign cap = (nlim > CW'(1)) ? nlim - CW'(1) : CW'(1);
  assign nclamp = (num_states > CW'(NS)) ? CW'(NS) : num_states;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; busy <= 1'b0; done <= 1'b0; overflow <= 1'b0;
      mark <= '0; pi <= '0; pj <= SW'(1); nlim <= '0; pass_cnt <= '0; changed <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph <= PH_INIT; busy <= 1'b1; done <= 1'b0; overflow <= 1'b0;
          mark <= '0; pi <= '0; pj <= SW'(1); nlim <= nclamp;
          pass_cnt <= CW'(1); changed <= 1'b0;
        end
        PH_INIT: begin
          mark[pidx(pi, pj)] <= init_mark;
          if (last_pair) begin
            ph <= PH_REF; pi <= '0; pj <= SW'(1); changed <= 1'b0;
          end else if (pj == SW'(NS - 1)) begin
            pi <= pi + SW'(1); pj <= pi + SW'(2);
          end else pj <= pj + SW'(1);
        end
        PH_REF: begin
          if (set_now) begin
            mark[pidx(pi, pj)] <= 1'b1;
            changed <= 1'b1;
          end
          if (last_pair) begin
            pi <= '0; pj <= SW'(1);
            if (quiet || pass_cnt == cap) begin
              ph <= PH_IDLE; busy <= 1'b0; done <= 1'b1; overflow <= !quiet;
            end else begin
              pass_cnt <= pass_cnt + CW'(1);
              changed <= 1'b0;
            end
          end else if (pj == SW'(NS - 1)) begin
            pi <= pi + SW'(1); pj <= pi + SW'(2);
          end else pj <= pj + SW'(1);
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_row
    for (genvar j = 0; j < NS; j++) begin : g_col
      if (i == j) begin : g_diag
        assign eq_pairs[i*NS+j] = inr(SW'(i));
      end else begin : g_off
        assign eq_pairs[i*NS+j] = inr(SW'(i)) && inr(SW'(j)) && !mark[pidx(SW'(i), SW'(j))];
      end
    end
  end

  always_comb begin
    int cnt;
    cnt = 0;
    rep_map = '0;
    for (int i = 0; i < NS; i++) begin
      logic [SW-1:0] r;
      logic hit;
      r = SW'(i);
      hit = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (!hit && inr(SW'(i)) && inr(SW'(j)) && !mark[pidx(SW'(j), SW'(i))]) begin
          r = SW'(j);
          hit = 1'b1;
        end
      end
      rep_map[i*SW +: SW] = r;
      if (inr(SW'(i)) && !hit) cnt++;
    end
    num_classes = CW'(cnt);
  end

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_table_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tns0) && $stable(tns1) && $stable(tout0) && $stable(tout1)));
  assert_marks_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_REF && $past(ph) == PH_REF) |-> ((mark & $past(mark)) == $past(mark)));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> done);
  for (genvar g = 0; g < NS; g++) begin : g_chk
    assert_rep_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rep_map[g*SW +: SW] <= SW'(g)));
  end
endmodule

// File: tb/state_equiv_finder_bench.sv
module state_equiv_finder_bench;
  localparam int NS = 8;
  localparam int SW = 3;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_out0 = 1'b0, wr_out1 = 1'b0, start = 1'b0;
  logic [SW-1:0] wr_state = '0, wr_ns0 = '0, wr_ns1 = '0;
  logic [CW-1:0] num_states = '0;
  logic busy, done, overflow;
  logic [NS*NS-1:0] eq_pairs;
  logic [NS*SW-1:0] rep_map;
  logic [CW-1:0] num_classes;

  state_equiv_finder u_state_equiv_finder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_state(wr_state),
    .wr_ns0(wr_ns0), .wr_ns1(wr_ns1), .wr_out0(wr_out0), .wr_out1(wr_out1),
    .num_states(num_states), .start(start), .busy(busy), .done(done),
    .overflow(overflow), .eq_pairs(eq_pairs), .rep_map(rep_map), .num_classes(num_classes));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [NS*SW-1:0] rep;
    logic [CW-1:0]    cls;
    logic [NS*NS-1:0] eq;
    string            tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  int m_ns0[NS], m_ns1[NS], m_o0[NS], m_o1[NS];
  int last_lat = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input int n, input string tag);
    exp_t e;
    bit eqm[NS][NS];
    bit chg;
    int lim, cnt;
    lim = (n > NS) ? NS : n;
    for (int i = 0; i < NS; i++)
      for (int j = 0; j < NS; j++)
        eqm[i][j] = (i == j) ? (i < lim) :
                    (i < lim && j < lim && m_o0[i] == m_o0[j] && m_o1[i] == m_o1[j]);
    do begin
      chg = 0;
      for (int i = 0; i < NS; i++)
        for (int j = 0; j < NS; j++)
          if (i != j && eqm[i][j]) begin
            bit k0, k1;
            k0 = (m_ns0[i] == m_ns0[j]) || eqm[m_ns0[i]][m_ns0[j]];
            k1 = (m_ns1[i] == m_ns1[j]) || eqm[m_ns1[i]][m_ns1[j]];
            if (!(k0 && k1)) begin eqm[i][j] = 0; chg = 1; end
          end
    end while (chg);
    cnt = 0;
    for (int i = 0; i < NS; i++) begin
      int r;
      r = i;
      for (int j = i - 1; j >= 0; j--) if (i < lim && eqm[i][j]) r = j;
      e.rep[i*SW +: SW] = SW'(r);
      if (i < lim && r == i) cnt++;
      for (int j = 0; j < NS; j++) e.eq[i*NS+j] = eqm[i][j];
    end
    e.cls = CW'(cnt);
    e.tag = tag;
    return e;
  endfunction

  task automatic load_all();
    for (int s = 0; s < NS; s++) begin
      wr_en = 1; wr_state = SW'(s);
      wr_ns0 = SW'(m_ns0[s]); wr_ns1 = SW'(m_ns1[s]);
      wr_out0 = m_o0[s][0]; wr_out1 = m_o1[s][0];
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  // action: 0 none, 1 write during run, 2 extra start during run
  task automatic run_case(input int n, input string tag, input bit do_load, input int action);
    int lat;
    if (do_load) load_all();
    sb.push_back(model(n, tag));
    num_states = CW'(n);
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R7", "busy after start", busy, 1);
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
      if (lat == 5) begin
        if (action == 1) begin
          wr_en = 1; wr_state = 3; wr_ns0 = 0; wr_ns1 = 0; wr_out0 = 0; wr_out1 = 0;
        end
        if (action == 2) start = 1;
      end
      if (lat == 6) begin wr_en = 0; start = 0; end
    end
    last_lat = lat;
    @(negedge clk);
  endtask

  // monitor: compare each completed run against the scoreboard
  bit done_prev = 0;
  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      if (sb.size() == 0) check(0, "R7", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(eq_pairs === e.eq, e.tag, "eq_pairs", eq_pairs, e.eq);
        check(rep_map === e.rep, "R6", {e.tag, " rep_map"}, rep_map, e.rep);
        check(num_classes === e.cls, "R6", {e.tag, " num_classes"}, num_classes, e.cls);
        check(overflow === 1'b0, "R9", "overflow", overflow, 0);
      end
    end
    done_prev = done;
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", "timeout", 0, 1);
    finish_up();
  end

  initial begin
    int lat_ref;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && done === 0 && overflow === 0, "R1", "status after reset",
          {busy, done, overflow}, 0);
    check(num_classes === 0, "R1", "classes after reset", num_classes, 0);

    // R4: self-referring and identical implied pairs; 0,1,2 merge, 3 differs in output
    m_ns0 = '{3, 3, 3, 0, 0, 0, 0, 0}; m_ns1 = '{2, 2, 0, 1, 0, 0, 0, 0};
    m_o0  = '{0, 0, 0, 1, 0, 0, 0, 0}; m_o1  = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_case(4, "R4", 1, 0);
    check(num_classes === 2, "R4", "classes of merged table", num_classes, 2);
    lat_ref = last_lat;

    // R7: extra start mid-run is ignored, same latency
    run_case(4, "R7", 0, 2);
    check(last_lat == lat_ref, "R7", "latency with extra start", last_lat, lat_ref);

    // R8: write during run dropped; rerun shows unchanged table
    run_case(4, "R8", 0, 1);
    run_case(4, "R8", 0, 0);
    check(num_classes === 2, "R8", "classes after dropped write", num_classes, 2);

    // R3: 8-state counter, output only at state 7 with x=1; needs many sweeps
    for (int s = 0; s < NS; s++) begin
      m_ns0[s] = s; m_ns1[s] = (s + 1) % NS; m_o0[s] = 0; m_o1[s] = (s == 7);
    end
    run_case(8, "R3", 1, 0);
    check(num_classes === 8, "R3", "all distinct", num_classes, 8);

    // R2: outputs split by parity only
    for (int s = 0; s < NS; s++) begin
      m_ns0[s] = s; m_ns1[s] = s; m_o0[s] = s % 2; m_o1[s] = 0;
    end
    run_case(8, "R2", 1, 0);
    check(num_classes === 2, "R2", "parity classes", num_classes, 2);

    // R6: all states identical
    for (int s = 0; s < NS; s++) begin
      m_ns0[s] = (s + 3) % NS; m_ns1[s] = (s * 5) % NS; m_o0[s] = 1; m_o1[s] = 1;
    end
    run_case(8, "R6", 1, 0);
    check(rep_map === '0, "R6", "single class map", rep_map, 0);

    // R5: limit below table size, out-of-range next states, clamping, tiny sizes
    m_ns0 = '{1, 2, 0, 7, 0, 0, 0, 0}; m_ns1 = '{0, 0, 0, 0, 6, 0, 0, 0};
    m_o0  = '{0, 0, 0, 0, 0, 0, 0, 0}; m_o1  = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_case(5, "R5", 1, 0);
    run_case(15, "R5", 0, 0);
    run_case(1, "R5", 0, 0);
    check(num_classes === 1, "R5", "single state", num_classes, 1);
    run_case(0, "R5", 0, 0);

    // random tables
    for (int t = 0; t < 24; t++) begin
      int n;
      n = $urandom_range(2, 8);
      for (int s = 0; s < NS; s++) begin
        m_ns0[s] = (t % 4 == 0) ? $urandom_range(0, 7) : $urandom_range(0, n - 1);
        m_ns1[s] = $urandom_range(0, n - 1);
        m_o0[s]  = ($urandom_range(0, 3) == 0);
        m_o1[s]  = (t % 2) ? 0 : $urandom_range(0, 1);
      end
      run_case(n, (t % 2) ? "R3" : "R2", 1, 0);
    end

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R7", "runs left unanswered", sb.size(), 0);
    finish_up();
  end
endmodule